// File: doc/BRIEF.md
# Shadow and SMRAM Memory Decoder

This block steers every processor memory access either to local DRAM or out to the PCI bus. It does this from the access address, a read/write flag and a flag that marks accesses made in system management mode. The `toDram` output is combinational from the current access and the configuration registers. It selects DRAM when high and PCI when low.

Three kinds of address range are decoded:

- **Shadow window, 0xC0000 to 0xFFFFF.** It is cut into thirteen regions. Each region has its own read-enable and write-enable bits, and these bits are packed as nibbles into seven attribute bytes.
- **SMRAM window, 0xA0000 to 0xBFFFF.** Its visibility depends on whether the access is a management-mode access, and on an open bit and an enable bit.
- **Everything else.** Any other address goes to DRAM when it lies below a top-of-memory limit. That limit is kept in 8 MB units.

A byte-wide configuration write port loads the attribute bytes, the SMRAM control byte and the memory size byte. A write becomes visible on the cycle after the clock edge that captures it.

Top module: `mem_route_decoder`

## Requirements
- R1: After reset, every attribute byte is 0x00 and the SMRAM control byte is 0x02. As a result, all shadow-window accesses and all SMRAM-window accesses, in either mode, go to PCI (`toDram` = 0).
- R2: Region mapping:
  - Region 0 is 0xF0000..0xFFFFF and uses the high nibble of the byte at offset 0x59.
  - Region r (1..12) is the 16 KB block starting at 0xC0000 + (r-1)*0x4000. It uses the byte at offset 0x59 + (r+1)/2: the low nibble when r is odd, the high nibble when r is even.
  - The low nibble of 0x59 affects no region.
- R3: In a shadow region, a read goes to DRAM exactly when bit 0 of that region's nibble is 1.
- R4: In a shadow region, a write goes to DRAM exactly when bit 1 of that region's nibble is 1. The write decision does not depend on bit 0.
- R5: A non-management access in 0xA0000..0xBFFFF goes to DRAM exactly when bit 6 (open) of the SMRAM byte at offset 0x72 is 1.
- R6: A management-mode access (`accSmm` = 1) in 0xA0000..0xBFFFF goes to DRAM exactly when bit 3 (enable) of the SMRAM byte is 1. Bit 6 has no effect on such an access.
- R7: An address outside 0xA0000..0xFFFFF goes to DRAM when it is below size*8 MB, where size is the byte at offset 0x57. At or above that limit it goes to PCI.
- R8: A configuration write with `cfgWrEn` = 1 loads the byte at `cfgAddr` at the clock edge, and the routing reflects it from the next cycle. Writes to offsets other than 0x57, 0x59..0x5F and 0x72 change no routing.
- R9: The size byte resets to `MEM_MB`/8, saturated at 255.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Configuration byte write strobe |
| cfgAddr | input | 8 | Configuration byte offset |
| cfgData | input | 8 | Configuration write data |
| accAddr | input | ADDR_W | Memory access address |
| accWrite | input | 1 | 1 = write access, 0 = read access |
| accSmm | input | 1 | 1 = access made in system management mode |
| toDram | output | 1 | 1 = route to DRAM, 0 = route to PCI |

## Verification
Directed cases cover the following patterns, each of which separates one family of faults:

- **Region pairs sharing one attribute byte.** Writing different nibbles to such a pair exposes a swapped nibble or an off-by-one region index.
- **Attribute values that enable only reads or only writes.** These separate the read bit from the write bit.
- **Management and non-management accesses under every combination of the open and enable bits.** These show which bit governs which mode.
- **Addresses one below and exactly at the top-of-memory limit.** These pin the comparison, including the limit of a second instance whose reset size saturates.

Constrained random traffic then mixes attribute, SMRAM, size and unrelated-offset writes with accesses biased into each window and near the limit. It is checked against a bench model of the register rules.

// File: rtl/memdec_pkg.sv
package memdec_pkg;
  localparam int NUM_REGIONS   = 13;
  localparam int SHADOW_BYTES  = (NUM_REGIONS + 1) / 2;
  localparam int SHADOW_IDX_W  = $clog2(SHADOW_BYTES);
  localparam logic [7:0] OFF_SIZE   = 8'h57;
  localparam logic [7:0] OFF_SHADOW = 8'h59;
  localparam logic [7:0] OFF_SMRAM  = 8'h72;
  localparam logic [7:0] SMRAM_RST  = 8'h02;
  localparam int BIT_OPEN   = 6;
  localparam int BIT_ENABLE = 3;
  localparam int UNIT_SHIFT = 23;   // 8 MB units

  typedef struct packed {
    logic                    wrShadow;
    logic [SHADOW_IDX_W-1:0] shadowIdx;
    logic                    wrSmram;
    logic                    wrSize;
    logic [7:0]              data;
  } cfgStrobe_t;
endpackage

// File: rtl/memdec_ctrl.sv
module memdec_ctrl
  import memdec_pkg::*;
(
  input  logic       cfgWrEn,
  input  logic [7:0] cfgAddr,
  input  logic [7:0] cfgData,
  output cfgStrobe_t stb
);
  logic [7:0] shadowOff;

  always_comb begin
    shadowOff     = cfgAddr - OFF_SHADOW;
    stb.wrShadow  = cfgWrEn && (cfgAddr >= OFF_SHADOW)
                    && (shadowOff < 8'(SHADOW_BYTES));
    stb.shadowIdx = shadowOff[SHADOW_IDX_W-1:0];
    stb.wrSmram   = cfgWrEn && (cfgAddr == OFF_SMRAM);
    stb.wrSize    = cfgWrEn && (cfgAddr == OFF_SIZE);
    stb.data      = cfgData;
  end
endmodule

// File: rtl/memdec_path.sv
module memdec_path
  import memdec_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int MEM_MB = 128
) (
  input  logic              clk,
  input  logic              rstN,
  input  cfgStrobe_t        stb,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic              accWrite,
  input  logic              accSmm,
  output logic              toDram
);
  localparam int         SIZE_UNITS = MEM_MB / 8;
  localparam logic [7:0] SIZE_RST   = (SIZE_UNITS > 255) ? 8'd255 : 8'(SIZE_UNITS);

  logic [7:0] shadowReg [SHADOW_BYTES];
  logic [7:0] smramReg;
  logic [7:0] sizeReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int b = 0; b < SHADOW_BYTES; b++) shadowReg[b] <= 8'h00;
      smramReg <= SMRAM_RST;
      sizeReg  <= SIZE_RST;
    end else begin
      for (int b = 0; b < SHADOW_BYTES; b++)
        if (stb.wrShadow && stb.shadowIdx == SHADOW_IDX_W'(b))
          shadowReg[b] <= stb.data;
      if (stb.wrSmram) smramReg <= stb.data;
      if (stb.wrSize)  sizeReg  <= stb.data;
    end
  end

  logic                    inSmram, inExp, inBios;
  logic [3:0]              expSlot;
  logic [SHADOW_IDX_W-1:0] byteSel;
  logic                    useHigh;
  logic [7:0]              attrByte;
  logic [3:0]              attrNib;
  logic [ADDR_W-1:0]       topAddr;

  always_comb begin
    inSmram  = (accAddr >= ADDR_W'(32'h000A0000)) && (accAddr < ADDR_W'(32'h000C0000));
    inExp    = (accAddr >= ADDR_W'(32'h000C0000)) && (accAddr < ADDR_W'(32'h000F0000));
    inBios   = (accAddr >= ADDR_W'(32'h000F0000)) && (accAddr < ADDR_W'(32'h00100000));
    expSlot  = accAddr[17:14];
    byteSel  = inBios ? '0 : SHADOW_IDX_W'(expSlot[3:1]) + SHADOW_IDX_W'(1);
    useHigh  = inBios | expSlot[0];
    attrByte = shadowReg[byteSel];
    attrNib  = useHigh ? attrByte[7:4] : attrByte[3:0];
    topAddr  = ADDR_W'(sizeReg) << UNIT_SHIFT;
    if (inSmram)
      toDram = accSmm ? smramReg[BIT_ENABLE] : smramReg[BIT_OPEN];
    else if (inExp || inBios)
      toDram = accWrite ? attrNib[1] : attrNib[0];
    else
      toDram = accAddr < topAddr;
  end
endmodule

// File: rtl/mem_route_decoder.sv
module mem_route_decoder
  import memdec_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int MEM_MB = 128
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [7:0]        cfgAddr,
  input  logic [7:0]        cfgData,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic              accWrite,
  input  logic              accSmm,
  output logic              toDram
);
  cfgStrobe_t stb;

  memdec_ctrl u_ctrl (
    .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr), .cfgData(cfgData), .stb(stb)
  );

  memdec_path #(.ADDR_W(ADDR_W), .MEM_MB(MEM_MB)) u_path (
    .clk(clk), .rstN(rstN), .stb(stb), .accAddr(accAddr),
    .accWrite(accWrite), .accSmm(accSmm), .toDram(toDram)
  );
endmodule

// File: rtl/mem_route_decoder_chk.sv
module mem_route_decoder_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              cfgWrEn,
  input logic [7:0]        cfgAddr,
  input logic [7:0]        cfgData,
  input logic [ADDR_W-1:0] accAddr,
  input logic              accWrite,
  input logic              accSmm,
  input logic              toDram,
  input logic [7:0]        smramReg,
  input logic [7:0]        sizeReg,
  input logic [7:0]        biosByte
);
  logic inSmram, inBios, inLegacy, aboveTop;
  assign inSmram  = (accAddr >= ADDR_W'(32'h000A0000)) && (accAddr < ADDR_W'(32'h000C0000));
  assign inBios   = (accAddr >= ADDR_W'(32'h000F0000)) && (accAddr < ADDR_W'(32'h00100000));
  assign inLegacy = (accAddr >= ADDR_W'(32'h000A0000)) && (accAddr < ADDR_W'(32'h00100000));
  assign aboveTop = accAddr >= (ADDR_W'(sizeReg) << 23);

  AST_SMM_CLOSED: assert property (@(posedge clk) disable iff (!rstN)
    (accSmm && inSmram && !smramReg[3]) |-> !toDram); // R6
  AST_NONSMM_CLOSED: assert property (@(posedge clk) disable iff (!rstN)
    (!accSmm && inSmram && !smramReg[6]) |-> !toDram); // R5
  AST_ABOVE_TOP: assert property (@(posedge clk) disable iff (!rstN)
    (!inLegacy && aboveTop) |-> !toDram); // R7
  AST_BIOS_READ_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (inBios && !accWrite && !biosByte[4]) |-> !toDram); // R3
  AST_BIOS_WRITE_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (inBios && accWrite && !biosByte[5]) |-> !toDram); // R4
  AST_SMRAM_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrEn && cfgAddr == 8'h72) |=> (smramReg == $past(cfgData))); // R8
  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !cfgWrEn |=> ($stable(smramReg) && $stable(sizeReg) && $stable(biosByte))); // R8
endmodule

bind mem_route_decoder mem_route_decoder_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
  .cfgData(cfgData), .accAddr(accAddr), .accWrite(accWrite),
  .accSmm(accSmm), .toDram(toDram), .smramReg(u_path.smramReg),
  .sizeReg(u_path.sizeReg), .biosByte(u_path.shadowReg[0])
);

// File: tb/mem_route_decoder_test.sv
module mem_route_decoder_test;
  localparam int ADDR_W = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWrEn = 1'b0;
  logic [7:0] cfgAddr = '0, cfgData = '0;
  logic [ADDR_W-1:0] accAddr = '0;
  logic accWrite = 1'b0, accSmm = 1'b0;
  logic toDram, satDram;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [7:0] mShadow [7];
  logic [7:0] mSmram, mSize;

  always #5 clk = ~clk;

  mem_route_decoder #(.ADDR_W(ADDR_W), .MEM_MB(128)) uut (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .cfgData(cfgData), .accAddr(accAddr), .accWrite(accWrite),
    .accSmm(accSmm), .toDram(toDram)
  );

  mem_route_decoder #(.ADDR_W(ADDR_W), .MEM_MB(4096)) satUut (
    .clk(clk), .rstN(rstN), .cfgWrEn(1'b0), .cfgAddr(8'h00),
    .cfgData(8'h00), .accAddr(accAddr), .accWrite(accWrite),
    .accSmm(accSmm), .toDram(satDram)
  );

  function automatic bit expDram(logic [31:0] a, bit wr, bit smm);
    int region, byteIdx;
    logic [3:0] nib;
    if (a >= 32'hA0000 && a < 32'hC0000)
      return smm ? mSmram[3] : mSmram[6];
    if (a >= 32'hC0000 && a < 32'h100000) begin
      region  = (a >= 32'hF0000) ? 0 : int'((a - 32'hC0000) / 32'h4000) + 1;
      byteIdx = (region + 1) / 2;
      nib     = (region % 2 == 1) ? mShadow[byteIdx][3:0] : mShadow[byteIdx][7:4];
      return wr ? nib[1] : nib[0];
    end
    return a < ({24'd0, mSize} << 23);
  endfunction

  task automatic check(bit got, bit exp, string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: toDram=%0d expected=%0d addr=%h wr=%0d smm=%0d",
               tag, got, exp, accAddr, accWrite, accSmm);
    end
  endtask

  task automatic cfgWrite(logic [7:0] off, logic [7:0] val);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgAddr = off; cfgData = val;
    @(posedge clk); #1;
    cfgWrEn = 1'b0;
    if (off >= 8'h59 && off <= 8'h5F) mShadow[off - 8'h59] = val;
    else if (off == 8'h72) mSmram = val;
    else if (off == 8'h57) mSize = val;
  endtask

  task automatic access(logic [31:0] a, bit wr, bit smm, string tag);
    @(negedge clk);
    accAddr = a; accWrite = wr; accSmm = smm;
    #2;
    check(toDram, expDram(a, wr, smm), tag);
  endtask

  initial begin
    int cyc = 0;
    while (!done && cyc < 190000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run hung, actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int seedDummy;
    for (int b = 0; b < 7; b++) mShadow[b] = 8'h00;
    mSmram = 8'h02;
    mSize = 8'd16;
    seedDummy = $urandom(32'd1234);
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1 reset state
    access(32'hF0000, 0, 0, "R1 bios read after reset");
    access(32'hC4000, 1, 0, "R1 expansion write after reset");
    access(32'hA0000, 0, 0, "R1 smram nonsmm after reset");
    access(32'hBFFFF, 0, 1, "R1 smram smm after reset");
    // R9 size reset and saturation
    access(32'h07FFFFFF, 0, 0, "R9 below reset top");
    access(32'h08000000, 0, 0, "R9 at reset top");
    @(negedge clk); accAddr = 32'h7F7FFFFF; #2; checks++;
    if (satDram !== 1'b1) begin errors++; $display("FAIL R9 saturated below top: got=%0d expected=1", satDram); end
    @(negedge clk); accAddr = 32'h7F800000; #2; checks++;
    if (satDram !== 1'b0) begin errors++; $display("FAIL R9 saturated at top: got=%0d expected=0", satDram); end

    // R2 region pair sharing one byte; R3/R4 read-only vs write-only
    cfgWrite(8'h5A, 8'h21);
    access(32'hC0000, 0, 0, "R2 R3 region1 low nibble read");
    access(32'hC0000, 1, 0, "R2 R4 region1 write disabled");
    access(32'hC4000, 0, 0, "R2 R3 region2 read disabled");
    access(32'hC7FFF, 1, 0, "R2 R4 region2 high nibble write");
    cfgWrite(8'h5F, 8'h30);
    access(32'hEC000, 0, 0, "R2 region12 read");
    access(32'hE8000, 1, 0, "R2 region11 write");
    cfgWrite(8'h59, 8'h0F);
    access(32'hF0000, 0, 0, "R2 bios ignores low nibble");
    cfgWrite(8'h59, 8'h10);
    access(32'hFFFFF, 0, 0, "R3 bios read enabled");
    access(32'hFFFFF, 1, 0, "R4 bios write disabled");

    // R5/R6 smram bit combinations
    for (int v = 0; v < 4; v++) begin
      cfgWrite(8'h72, 8'h02 | (v[0] ? 8'h40 : 8'h00) | (v[1] ? 8'h08 : 8'h00));
      access(32'hB0000, 0, 0, "R5 smram nonsmm");
      access(32'hB0000, 1, 1, "R6 smram smm");
    end

    // R8 ignored offset
    cfgWrite(8'h58, 8'hFF);
    access(32'hFFFFF, 1, 0, "R8 unrelated write ignored bios");
    access(32'h08000000, 0, 0, "R8 unrelated write ignored top");

    // R7 size change
    cfgWrite(8'h57, 8'd2);
    access(32'h00FFFFFF, 0, 0, "R7 below new top");
    access(32'h01000000, 1, 0, "R7 at new top");
    access(32'h0009FFFF, 0, 0, "R7 low memory");

    // random mix
    for (int i = 0; i < 4000; i++) begin
      int cat;
      logic [31:0] a;
      logic [7:0] off;
      cat = int'($urandom % 6);
      if (cat == 5) begin
        case ($urandom % 4)
          0: off = 8'h57;
          1: off = 8'h59 + 8'($urandom % 7);
          2: off = 8'h72;
          default: off = 8'($urandom);
        endcase
        cfgWrite(off, (off == 8'h57) ? 8'($urandom % 32) : 8'($urandom));
      end else begin
        case (cat)
          0: a = 32'hA0000 + ($urandom % 32'h20000);
          1: a = 32'hC0000 + ($urandom % 32'h30000);
          2: a = 32'hF0000 + ($urandom % 32'h10000);
          3: a = ({24'd0, mSize} << 23) + ($urandom % 8) - 4;
          default: a = $urandom;
        endcase
        access(a, 1'($urandom), 1'($urandom), "R2 R3 R4 R5 R6 R7 random");
      end
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule